// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is the control sequencer for one channel of a DMA controller. Software writes a start command. The channel then checks its configuration and enters a waiting state with its running flag set. From there it asks for the bus, either at once or when an external peripheral raises its request line. Each time the bus is granted, the block issues one strobe that launches a single transfer unit. The datapath around the block does the addressing, moves the data and keeps the byte count. It reports back with a unit-done handshake and a flag that says the count has reached zero.

A run can end in two ways.

- **Normal ending.** The byte count runs out, software writes stop, or a peripheral pulls the active-low done input low. In every one of these cases the transfer unit that is in progress is allowed to finish first. In continue mode only the stop command ends the run. A zero count or a done pulse just closes the current operation, and the channel asks for the bus again.
- **Abnormal ending.** This comes from a bad configuration, a forced abort, a bus error reported with the unit-done handshake, or a start written while an older completion flag is still set.

Completion flags stay set until software clears them by writing 1.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, bus_req, unit_start, st_active, st_nc and st_abc are all 0.
- R2: A start written from idle with cfg_err high sets st_abc on the second clock edge. st_active and bus_req stay 0.
- R3: A start written from idle, with both completion flags clear and cfg_err low, sets st_active on the second clock edge. st_active stays 1 until the run completes, and bus_req is only ever 1 while st_active is 1.
- R4: With mode_ext=0 (internal requests), bus_req rises on the clock edge after st_active rises, without any external request.
- R5: With mode_ext=1 (external requests), bus_req stays 0 in the waiting state while ext_req is low. It rises on the edge at which ext_req is sampled high.
- R6: unit_start is high only while bus_req and bus_grant are both high, and it lasts exactly one cycle for each grant.
- R7: A start written while st_nc or st_abc is 1 does not start the channel. It sets st_abc on the next edge, and st_active stays 0.
- R8: When cont_mode=0, unit_done with bc_zero=1 sets st_nc and clears st_active on that same edge.
- R9: A low pulse on done_n during a unit is remembered after done_n returns high. The run ends normally on that unit's unit_done, and not before.
- R10: A stop written in the waiting state sets st_nc on the next edge. A stop written while a unit is in progress only takes effect on that unit's unit_done.
- R11: With cont_mode=1, bc_zero or done_n at unit_done does not complete the run. st_active stays 1 and a new unit is requested. Only a stop ends the run.
- R12: abort_req while running, or xfer_err sampled with unit_done, sets st_abc and clears st_active and bus_req on that edge.
- R13: clr_nc and clr_abc (write 1 to clear) each clear only their own flag. st_active is never 1 while st_nc or st_abc is 1.
- R14: A stop written while idle has no effect: no completion flag is set and a later start still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_wr | input | 1 | One-cycle pulse: software writes the start command |
| stop_wr | input | 1 | One-cycle pulse: software writes the stop command |
| clr_nc | input | 1 | Write-1-to-clear strobe for the normal-completion flag |
| clr_abc | input | 1 | Write-1-to-clear strobe for the abnormal-completion flag |
| mode_ext | input | 1 | 1: wait for ext_req; 0: request the bus internally |
| cont_mode | input | 1 | 1: only stop ends the run |
| cfg_err | input | 1 | Configuration checker reports an error |
| ext_req | input | 1 | Peripheral transfer request |
| done_n | input | 1 | Active-low early termination from a peripheral |
| bc_zero | input | 1 | Byte count has reached zero (from datapath) |
| bus_grant | input | 1 | Bus ownership granted |
| unit_done | input | 1 | Current transfer unit has finished |
| abort_req | input | 1 | Forced termination |
| xfer_err | input | 1 | Bus error, qualified by unit_done |
| bus_req | output | 1 | Bus request, held from request until the unit ends |
| unit_start | output | 1 | One-cycle strobe launching a transfer unit |
| st_active | output | 1 | Status: channel running |
| st_nc | output | 1 | Status: normal completion |
| st_abc | output | 1 | Status: abnormal completion |

## Verification
The hardest cases to reach are the deferred endings. A done pulse or a stop write only counts if it arrives while a unit is in progress, and it must not act until a later unit_done. The stimulus gets there by holding the grant high, waiting until unit_start is seen, and then pulsing done_n or stop_wr one cycle into the unit. It lets the pulse lapse and checks that no completion flag appears before unit_done is driven. Continue mode is reached the same way, by running several units back to back with bc_zero set and then ending the run with a stop.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    CH_IDLE,
    CH_CHECK,
    CH_WAIT,
    CH_REQ,
    CH_XFER,
    CH_DONE
  } ch_state_e;

  typedef enum logic [1:0] {
    UE_NEXT,
    UE_NORMAL,
    UE_ABNORMAL
  } unit_end_e;

  // Decide what happens when a transfer unit finishes.
  function automatic unit_end_e classify_unit_end(input logic err,
                                                  input logic stop,
                                                  input logic cause,
                                                  input logic cont);
    if (err)                return UE_ABNORMAL;
    else if (stop)          return UE_NORMAL;
    else if (cause && !cont) return UE_NORMAL;
    else                    return UE_NEXT;
  endfunction

  // A run may begin only when no completion flag is pending.
  function automatic logic may_start(input logic nc, input logic abc);
    return !(nc || abc);
  endfunction

endpackage

// File: rtl/dma_chan_sticky.sv
module dma_chan_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic seen_o
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end

  // Live event or remembered event.
  assign seen_o = q | set_i;

endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_wait,
  input  logic ev_norm,
  input  logic ev_abn,
  input  logic ev_refuse,
  input  logic clr_nc,
  input  logic clr_abc,
  output logic active_o,
  output logic nc_o,
  output logic abc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      nc_o     <= 1'b0;
      abc_o    <= 1'b0;
    end else begin
      if (ev_norm || ev_abn) active_o <= 1'b0;
      else if (ev_wait)      active_o <= 1'b1;
      // A set event beats a clear strobe in the same cycle.
      if (ev_norm)      nc_o <= 1'b1;
      else if (clr_nc)  nc_o <= 1'b0;
      if (ev_abn || ev_refuse) abc_o <= 1'b1;
      else if (clr_abc)        abc_o <= 1'b0;
    end
  end

  a_r13_active_excludes_completion: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !(nc_o || abc_o));

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_wr,
  input  logic      blocked,
  input  logic      cfg_err,
  input  logic      mode_ext,
  input  logic      ext_req,
  input  logic      stop_pend,
  input  logic      end_cause,
  input  logic      cont_mode,
  input  logic      bus_grant,
  input  logic      unit_done,
  input  logic      abort_req,
  input  logic      xfer_err,
  output ch_state_e state,
  output logic      bus_req,
  output logic      unit_start,
  output logic      unit_close,
  output logic      ev_wait,
  output logic      ev_norm,
  output logic      ev_abn,
  output logic      ev_refuse
);
  ch_state_e nxt;
  unit_end_e ue;

  assign ue = classify_unit_end(xfer_err, stop_pend, end_cause, cont_mode);

  always_comb begin
    nxt        = state;
    bus_req    = 1'b0;
    unit_start = 1'b0;
    unit_close = 1'b0;
    ev_wait    = 1'b0;
    ev_norm    = 1'b0;
    ev_abn     = 1'b0;
    ev_refuse  = 1'b0;
    case (state)
      CH_IDLE: begin
        if (start_wr) begin
          if (blocked) ev_refuse = 1'b1;
          else         nxt = CH_CHECK;
        end
      end
      CH_CHECK: begin
        if (cfg_err) begin
          ev_abn = 1'b1;
          nxt    = CH_DONE;
        end else begin
          ev_wait = 1'b1;
          nxt     = CH_WAIT;
        end
      end
      CH_WAIT: begin
        if (abort_req) begin
          ev_abn = 1'b1;
          nxt    = CH_DONE;
        end else if (stop_pend) begin
          ev_norm = 1'b1;
          nxt     = CH_DONE;
        end else if (!mode_ext || ext_req) begin
          nxt = CH_REQ;
        end
      end
      CH_REQ: begin
        bus_req = 1'b1;
        if (abort_req) begin
          ev_abn = 1'b1;
          nxt    = CH_DONE;
        end else if (bus_grant) begin
          unit_start = 1'b1;
          nxt        = CH_XFER;
        end
      end
      CH_XFER: begin
        bus_req = 1'b1;
        if (abort_req) begin
          ev_abn     = 1'b1;
          unit_close = 1'b1;
          nxt        = CH_DONE;
        end else if (unit_done) begin
          unit_close = 1'b1;
          case (ue)
            UE_NORMAL: begin
              ev_norm = 1'b1;
              nxt     = CH_DONE;
            end
            UE_ABNORMAL: begin
              ev_abn = 1'b1;
              nxt    = CH_DONE;
            end
            default: nxt = CH_WAIT;
          endcase
        end
      end
      CH_DONE: nxt = CH_IDLE;
      default: nxt = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CH_IDLE;
    else        state <= nxt;
  end

  a_r6_unit_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |=> !unit_start);

  a_r6_unit_start_in_xfer_next: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |=> (state == CH_XFER));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic stop_wr,
  input  logic clr_nc,
  input  logic clr_abc,
  input  logic mode_ext,
  input  logic cont_mode,
  input  logic cfg_err,
  input  logic ext_req,
  input  logic done_n,
  input  logic bc_zero,
  input  logic bus_grant,
  input  logic unit_done,
  input  logic abort_req,
  input  logic xfer_err,
  output logic bus_req,
  output logic unit_start,
  output logic st_active,
  output logic st_nc,
  output logic st_abc
);
  ch_state_e state;
  logic unit_close, ev_wait, ev_norm, ev_abn, ev_refuse;
  logic stop_pend, done_seen, blocked, end_cause;
  logic stop_set, stop_clr, done_set, done_clr;

  assign blocked   = !may_start(st_nc, st_abc);
  assign stop_set  = stop_wr && (state != CH_IDLE) && (state != CH_DONE);
  assign stop_clr  = (state == CH_IDLE) || (state == CH_DONE);
  assign done_set  = (state == CH_XFER) && !done_n;
  assign done_clr  = unit_close || (state == CH_IDLE);
  assign end_cause = bc_zero || done_seen;

  dma_chan_sticky u_stop (
    .clk(clk), .rst_n(rst_n), .set_i(stop_set), .clr_i(stop_clr), .seen_o(stop_pend)
  );

  dma_chan_sticky u_done (
    .clk(clk), .rst_n(rst_n), .set_i(done_set), .clr_i(done_clr), .seen_o(done_seen)
  );

  dma_chan_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .blocked(blocked),
    .cfg_err(cfg_err), .mode_ext(mode_ext), .ext_req(ext_req),
    .stop_pend(stop_pend), .end_cause(end_cause), .cont_mode(cont_mode),
    .bus_grant(bus_grant), .unit_done(unit_done), .abort_req(abort_req),
    .xfer_err(xfer_err), .state(state), .bus_req(bus_req),
    .unit_start(unit_start), .unit_close(unit_close), .ev_wait(ev_wait),
    .ev_norm(ev_norm), .ev_abn(ev_abn), .ev_refuse(ev_refuse)
  );

  dma_chan_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_wait(ev_wait), .ev_norm(ev_norm),
    .ev_abn(ev_abn), .ev_refuse(ev_refuse), .clr_nc(clr_nc), .clr_abc(clr_abc),
    .active_o(st_active), .nc_o(st_nc), .abc_o(st_abc)
  );

  a_r3_req_only_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> st_active);

  a_r5_req_has_reason: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(!mode_ext || ext_req));

  a_r6_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |-> (bus_req && bus_grant));

  a_r10_nc_only_at_unit_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(st_nc) && $past(state == CH_XFER)) |-> $past(unit_done));

  a_r12_abn_stops_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_abc) |-> (!st_active && !bus_req));

endmodule

// File: tb/dma_chan_ctrl_test.sv
`timescale 1ns/1ps
module dma_chan_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_wr = 0, stop_wr = 0, clr_nc = 0, clr_abc = 0;
  logic mode_ext = 0, cont_mode = 0, cfg_err = 0, ext_req = 0;
  logic done_n = 1, bc_zero = 0, bus_grant = 1, unit_done = 0;
  logic abort_req = 0, xfer_err = 0;
  logic bus_req, unit_start, st_active, st_nc, st_abc;

  int checks = 0;
  int errors = 0;
  logic finished = 0;
  logic [1:0] expq[$];   // 2'b01 normal completion, 2'b10 abnormal
  localparam logic [1:0] EXP_NC  = 2'b01;
  localparam logic [1:0] EXP_ABC = 2'b10;

  always #4 clk = ~clk;

  dma_chan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .stop_wr(stop_wr),
    .clr_nc(clr_nc), .clr_abc(clr_abc), .mode_ext(mode_ext), .cont_mode(cont_mode),
    .cfg_err(cfg_err), .ext_req(ext_req), .done_n(done_n), .bc_zero(bc_zero),
    .bus_grant(bus_grant), .unit_done(unit_done), .abort_req(abort_req),
    .xfer_err(xfer_err), .bus_req(bus_req), .unit_start(unit_start),
    .st_active(st_active), .st_nc(st_nc), .st_abc(st_abc)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every rising completion flag pops one expected item.
  logic prev_nc = 0, prev_abc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((st_nc && !prev_nc) || (st_abc && !prev_abc)) begin
        logic [1:0] got;
        got = {st_abc && !prev_abc, st_nc && !prev_nc};
        if (expq.size() == 0) check(1'b0, "R13 unexpected completion", got, 0);
        else begin
          logic [1:0] e;
          e = expq.pop_front();
          check(got == e, "scoreboard completion kind", got, e);
        end
      end
      prev_nc  <= st_nc;
      prev_abc <= st_abc;
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_wr = 1;
    @(negedge clk) start_wr = 0;
  endtask

  task automatic clear_all();
    @(negedge clk) begin clr_nc = 1; clr_abc = 1; end
    @(negedge clk) begin clr_nc = 0; clr_abc = 0; end
  endtask

  task automatic wait_unit(input string req);
    for (int i = 0; i < 40 && !unit_start; i++) @(negedge clk);
    check(unit_start && bus_req, req, unit_start, 1);
  endtask

  task automatic run_unit(input logic bcz, input logic err, input string req);
    wait_unit(req);
    @(negedge clk) begin unit_done = 1; bc_zero = bcz; xfer_err = err; end
    @(negedge clk) begin unit_done = 0; bc_zero = 0; xfer_err = 0; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_req && !unit_start && !st_active && !st_nc && !st_abc, "R1 reset outputs",
          {bus_req, unit_start, st_active, st_nc, st_abc}, 0);
    rst_n = 1;

    // R2 configuration error
    cfg_err = 1;
    expq.push_back(EXP_ABC);
    pulse_start();
    @(negedge clk);
    check(st_abc && !st_active && !bus_req, "R2 cfg error abnormal", {st_abc, st_active}, 2);
    cfg_err = 0;
    clear_all();
    check(!st_abc, "R13 clear abnormal", st_abc, 0);

    // R3/R4/R8 internal normal run
    pulse_start();
    check(!st_active, "R3 not active after first edge", st_active, 0);
    @(negedge clk);
    check(st_active && !bus_req, "R3 active after second edge", {st_active, bus_req}, 2);
    @(negedge clk);
    check(bus_req, "R4 internal request", bus_req, 1);
    check(unit_start, "R6 strobe with grant", unit_start, 1);
    run_unit(0, 0, "R6 first unit");
    check(st_active && !st_nc, "R3 stays active between units", {st_active, st_nc}, 2);
    expq.push_back(EXP_NC);
    run_unit(1, 0, "R6 second unit");
    check(st_nc && !st_active && !bus_req, "R8 count zero completes", {st_nc, st_active}, 2);

    // R7 refused start
    expq.push_back(EXP_ABC);
    pulse_start();
    check(st_abc && !st_active, "R7 refuse sets abnormal", {st_abc, st_active}, 2);
    @(negedge clk);
    check(!st_active && !bus_req, "R7 stays idle", st_active, 0);
    @(negedge clk) clr_nc = 1;
    @(negedge clk) clr_nc = 0;
    check(!st_nc && st_abc, "R13 clear only normal flag", {st_nc, st_abc}, 1);
    clear_all();

    // R5/R9 external mode with done pulse
    mode_ext = 1;
    pulse_start();
    repeat (4) @(negedge clk);
    check(st_active && !bus_req, "R5 no request without ext_req", bus_req, 0);
    ext_req = 1;
    @(negedge clk) ext_req = 0;
    check(bus_req && unit_start, "R5 request after ext_req", bus_req, 1);
    @(negedge clk) done_n = 0;
    @(negedge clk) done_n = 1;
    @(negedge clk);
    check(!st_nc && st_active, "R9 done held until unit end", st_nc, 0);
    expq.push_back(EXP_NC);
    unit_done = 1;
    @(negedge clk) unit_done = 0;
    check(st_nc && !st_active, "R9 done completes at unit end", st_nc, 1);
    clear_all();

    // R10 stop in wait (external, no request)
    pulse_start();
    @(negedge clk);
    expq.push_back(EXP_NC);
    @(negedge clk) stop_wr = 1;
    @(negedge clk) stop_wr = 0;
    check(st_nc && !st_active, "R10 stop in wait", {st_nc, st_active}, 2);
    mode_ext = 0;
    clear_all();

    // R10 stop during a unit
    pulse_start();
    wait_unit("R10 unit launch");
    @(negedge clk) stop_wr = 1;
    @(negedge clk) stop_wr = 0;
    repeat (2) @(negedge clk);
    check(!st_nc && st_active, "R10 stop deferred", st_nc, 0);
    expq.push_back(EXP_NC);
    unit_done = 1;
    @(negedge clk) unit_done = 0;
    check(st_nc && !st_active, "R10 stop at unit end", st_nc, 1);
    clear_all();

    // R11 continue mode
    cont_mode = 1;
    pulse_start();
    run_unit(1, 0, "R11 unit one");
    check(st_active && !st_nc, "R11 count zero does not end", {st_active, st_nc}, 2);
    run_unit(1, 0, "R11 unit two re-requested");
    check(st_active && !st_nc, "R11 still active", {st_active, st_nc}, 2);
    expq.push_back(EXP_NC);
    @(negedge clk) stop_wr = 1;
    @(negedge clk) stop_wr = 0;
    repeat (4) @(negedge clk);
    if (st_active) begin
      unit_done = 1;
      @(negedge clk) unit_done = 0;
    end
    check(st_nc && !st_active, "R11 stop ends continue run", {st_nc, st_active}, 2);
    cont_mode = 0;
    clear_all();

    // R12 abort during unit
    pulse_start();
    wait_unit("R12 unit launch");
    expq.push_back(EXP_ABC);
    @(negedge clk) abort_req = 1;
    @(negedge clk) abort_req = 0;
    check(st_abc && !st_active && !bus_req, "R12 abort", {st_abc, st_active, bus_req}, 4);
    clear_all();

    // R12 bus error at unit end
    pulse_start();
    expq.push_back(EXP_ABC);
    run_unit(0, 1, "R12 unit launch err");
    check(st_abc && !st_active && !bus_req, "R12 bus error", {st_abc, st_active}, 2);
    clear_all();

    // R14 stop while idle ignored
    @(negedge clk) stop_wr = 1;
    @(negedge clk) stop_wr = 0;
    repeat (3) @(negedge clk);
    check(!st_nc && !st_abc && !st_active, "R14 idle stop ignored", {st_nc, st_abc}, 0);
    pulse_start();
    @(negedge clk);
    check(st_active, "R14 later start runs", st_active, 1);
    expq.push_back(EXP_NC);
    run_unit(1, 0, "R14 unit");
    check(st_nc, "R14 run completes", st_nc, 1);

    repeat (3) @(negedge clk);
    check(expq.size() == 0, "scoreboard drained", expq.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule